// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the control sequencer that services interrupts in a small 8-bit microcontroller core. It keeps a flag for each interrupt request line. Once the global interrupt-enable flag is set, it waits for the current instruction to reach its boundary, which may take several cycles. It then takes the lowest-numbered pending request. While it works it holds the fetch unit stalled. It saves the two-byte program counter onto a byte-wide stack that grows downward. It then loads the program counter with that request's vector address.

A return instruction starts the reverse sequence. The sequencer pops the two saved bytes, moves the stack pointer back up by two, loads the restored program counter and sets the global enable again. If the core is asleep, a request is taken only once the wake-up start-up has finished, which is signalled on a ready input. In that case the entry sequence costs four extra cycles. After an enable-interrupts instruction, the next instruction always completes before any pending request is taken. This holds even when that next instruction is a sleep.

Top module: `isr_sequencer`

## Requirements
- R1: A request is accepted only in a cycle where `insn_done_i` is high, the core is not sleeping, `gie_o` is 1, at least one flag in `irq_pend_o` is set and no shadow is active. `busy_o` rises in the next cycle, and no acceptance happens while `insn_done_i` is low.
- R2: After an accepted request, `busy_o` stays high for exactly four cycles. `pc_load_o` pulses in the fourth of them, with `pc_load_val_o` = VEC_BASE + 2 × index, where VEC_BASE defaults to 0x0002.
- R3: In the first entry cycle the stack port writes the low program-counter byte at the current stack pointer. In the second it writes the high byte at the pointer minus 1. No further writes follow, and `sp_o` ends two lower.
- R4: When several flags are pending, the lowest index is taken. Only its flag is cleared at acceptance, and the others stay pending.
- R5: `gie_o` is 0 from the cycle after an acceptance until a return completes.
- R6: While `sleeping_i` is high, a request is accepted only when `wake_ready_i` is high. `busy_o` then stays high for eight cycles. The vector load comes in the eighth cycle, and the two stack writes come in cycles five and six.
- R7: A boundary with `reti_exec_i` high starts a four-cycle return. It reads the stack at pointer+1 (the high byte) and then at pointer+2 (the low byte). It loads the restored value in the fourth cycle. Afterwards `sp_o` is two higher and `gie_o` is 1.
- R8: A boundary with `ei_exec_i` high sets `gie_o`. The next instruction boundary accepts no request, and the boundary after that may.
- R9: If the instruction right after the enable is the one that puts the core to sleep, no request is taken at its boundary. The pending request is taken from sleep once `wake_ready_i` is high.
- R10: A boundary with `di_exec_i` high clears `gie_o`. Requests that arrive afterwards stay pending and are not accepted.
- R11: After reset `busy_o`, `gie_o`, `stk_we_o`, `pc_load_o` and `irq_pend_o` are 0, and `sp_o` equals SP_INIT (default 0x3FF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_set_i | input | N_IRQ | One-cycle pulses that set the pending flags |
| insn_done_i | input | 1 | The current instruction completes in this cycle |
| ei_exec_i | input | 1 | The completing instruction enables interrupts |
| di_exec_i | input | 1 | The completing instruction disables interrupts |
| reti_exec_i | input | 1 | The completing instruction is a return from interrupt |
| sleeping_i | input | 1 | The core is in sleep |
| wake_ready_i | input | 1 | The wake-up start-up delay has elapsed |
| pc_cur_i | input | 16 | Program counter to save on entry |
| stk_rdata_i | input | 8 | Stack read data, combinational from `stk_addr_o` |
| stk_we_o | output | 1 | Stack write enable |
| stk_addr_o | output | SP_W | Stack address |
| stk_wdata_o | output | 8 | Stack write data |
| sp_o | output | SP_W | Stack pointer |
| pc_load_o | output | 1 | Program-counter load strobe |
| pc_load_val_o | output | 16 | Value to load into the program counter |
| busy_o | output | 1 | A sequence is running; fetch stalls |
| gie_o | output | 1 | Global interrupt enable |
| irq_pend_o | output | N_IRQ | Pending request flags |

## Verification
The assertions assume that `insn_done_i` is only asserted while `busy_o` is low. They also assume that at most one of the enable, disable and return strobes accompanies each boundary, and that the stack read data reflects what was written earlier. The bench keeps to these assumptions by running every entry and return sequence to completion before it signals another boundary. Its stack model is a byte array written on `stk_we_o` and read combinationally. The bench drops `sleeping_i` once a wake-up acceptance has been made.

// File: rtl/isr_pkg.sv
package isr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAKE   = 2'd1,
    ST_ENTER  = 2'd2,
    ST_RETURN = 2'd3
  } seq_state_t;

  // Vector of a request: base plus two words per index.
  function automatic logic [15:0] vector_addr(input logic [15:0] base,
                                              input logic [7:0]  idx);
    return base + {7'd0, idx, 1'b0};
  endfunction

  // Stack-pointer step used by push (down) and pop (up).
  function automatic logic [15:0] sp_step(input logic [15:0] sp,
                                          input logic        up);
    return up ? sp + 16'd1 : sp - 16'd1;
  endfunction
endpackage

// File: rtl/isr_pending.sv
module isr_pending #(
  parameter int N_IRQ = 8,
  localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] set_i,
  input  logic             take_i,
  output logic [N_IRQ-1:0] pend_o,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N_IRQ-1:0] pend_q;
  logic [N_IRQ-1:0] take_mask;

  // Lowest set index wins: scan from the top so the last hit is the lowest.
  always_comb begin
    idx_o = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (pend_q[i]) idx_o = IDX_W'(i);
    end
  end

  always_comb begin
    take_mask = '0;
    if (take_i) take_mask[idx_o] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~take_mask) | set_i;
  end

  assign pend_o = pend_q;
  assign any_o  = |pend_q;
endmodule

// File: rtl/isr_stack_ptr.sv
module isr_stack_ptr
  import isr_pkg::*;
#(
  parameter int            SP_W    = 10,
  parameter logic [SP_W-1:0] SP_INIT = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_i,
  input  logic            pop_i,
  output logic [SP_W-1:0] sp_o,
  output logic [SP_W-1:0] addr_o
);
  logic [SP_W-1:0] sp_q;
  logic [SP_W-1:0] sp_up;
  logic [SP_W-1:0] sp_dn;

  assign sp_up = SP_W'(sp_step(16'(sp_q), 1'b1));
  assign sp_dn = SP_W'(sp_step(16'(sp_q), 1'b0));

  always_ff @(posedge clk) begin
    if (!rst_n)      sp_q <= SP_INIT;
    else if (push_i) sp_q <= sp_dn;
    else if (pop_i)  sp_q <= sp_up;
  end

  // Push writes at the pointer; pop reads one above it.
  assign addr_o = pop_i ? sp_up : sp_q;
  assign sp_o   = sp_q;
endmodule

// File: rtl/isr_sequencer.sv
module isr_sequencer
  import isr_pkg::*;
#(
  parameter int              N_IRQ      = 8,
  parameter int              SP_W       = 10,
  parameter logic [SP_W-1:0] SP_INIT    = '1,
  parameter logic [15:0]     VEC_BASE   = 16'h0002,
  parameter int              WAKE_EXTRA = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_set_i,
  input  logic             insn_done_i,
  input  logic             ei_exec_i,
  input  logic             di_exec_i,
  input  logic             reti_exec_i,
  input  logic             sleeping_i,
  input  logic             wake_ready_i,
  input  logic [15:0]      pc_cur_i,
  input  logic [7:0]       stk_rdata_i,
  output logic             stk_we_o,
  output logic [SP_W-1:0]  stk_addr_o,
  output logic [7:0]       stk_wdata_o,
  output logic [SP_W-1:0]  sp_o,
  output logic             pc_load_o,
  output logic [15:0]      pc_load_val_o,
  output logic             busy_o,
  output logic             gie_o,
  output logic [N_IRQ-1:0] irq_pend_o
);
  localparam int IDX_W  = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;
  localparam int SEQ_LEN = 4;
  localparam int CNT_MAX = (WAKE_EXTRA > SEQ_LEN) ? WAKE_EXTRA : SEQ_LEN;
  localparam int CNT_W  = $clog2(CNT_MAX) + 1;

  seq_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             gie_q, shadow_q;
  logic [15:0]      pc_save_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       pop_hi_q, pop_lo_q;

  logic             any_pend;
  logic [IDX_W-1:0] pick_idx;
  logic             idle, bound, can_take;
  logic             acc_run, acc_wake, ret_start, push, pop, last_step;

  assign idle      = (state_q == ST_IDLE);
  assign bound     = idle && insn_done_i;
  assign can_take  = gie_q && any_pend && !shadow_q;
  assign acc_run   = bound && !sleeping_i && !reti_exec_i && can_take;
  assign acc_wake  = idle && sleeping_i && wake_ready_i && can_take;
  assign ret_start = bound && reti_exec_i && !sleeping_i;
  assign last_step = (cnt_q == CNT_W'(SEQ_LEN - 1));
  assign push      = (state_q == ST_ENTER)  && (cnt_q < CNT_W'(2));
  assign pop       = (state_q == ST_RETURN) && (cnt_q < CNT_W'(2));

  isr_pending #(.N_IRQ(N_IRQ)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (irq_set_i),
    .take_i (acc_run || acc_wake),
    .pend_o (irq_pend_o),
    .any_o  (any_pend),
    .idx_o  (pick_idx)
  );

  isr_stack_ptr #(.SP_W(SP_W), .SP_INIT(SP_INIT)) u_sp (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_i (push),
    .pop_i  (pop),
    .sp_o   (sp_o),
    .addr_o (stk_addr_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      gie_q     <= 1'b0;
      shadow_q  <= 1'b0;
      pc_save_q <= '0;
      idx_q     <= '0;
      pop_hi_q  <= '0;
      pop_lo_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (acc_run || acc_wake) begin
            gie_q     <= 1'b0;
            shadow_q  <= 1'b0;
            pc_save_q <= pc_cur_i;
            idx_q     <= pick_idx;
            state_q   <= acc_wake ? ST_WAKE : ST_ENTER;
          end else if (ret_start) begin
            shadow_q <= 1'b0;
            state_q  <= ST_RETURN;
          end else if (bound) begin
            shadow_q <= ei_exec_i;
            if (ei_exec_i)      gie_q <= 1'b1;
            else if (di_exec_i) gie_q <= 1'b0;
          end
        end
        ST_WAKE: begin
          if (cnt_q == CNT_W'(WAKE_EXTRA - 1)) begin
            cnt_q   <= '0;
            state_q <= ST_ENTER;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_ENTER: begin
          cnt_q <= cnt_q + 1'b1;
          if (last_step) state_q <= ST_IDLE;
        end
        ST_RETURN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(0)) pop_hi_q <= stk_rdata_i;
          if (cnt_q == CNT_W'(1)) pop_lo_q <= stk_rdata_i;
          if (last_step) begin
            gie_q   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign stk_we_o      = push;
  assign stk_wdata_o   = cnt_q[0] ? pc_save_q[15:8] : pc_save_q[7:0];
  assign pc_load_o     = ((state_q == ST_ENTER) || (state_q == ST_RETURN)) && last_step;
  assign pc_load_val_o = (state_q == ST_ENTER) ? vector_addr(VEC_BASE, 8'(idx_q))
                                               : {pop_hi_q, pop_lo_q};
  assign busy_o        = !idle;
  assign gie_o         = gie_q;
endmodule

// File: rtl/isr_seq_checker.sv
module isr_seq_checker #(
  parameter int SP_W = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            insn_done_i,
  input logic            ei_exec_i,
  input logic            busy_o,
  input logic            pc_load_o,
  input logic            gie_o,
  input logic            stk_we_o,
  input logic [SP_W-1:0] sp_o,
  input logic            acc_run,
  input logic            acc_wake,
  input logic            ret_start
);
  a_r1_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    acc_run |-> insn_done_i);

  a_r1_busy_next: assert property (@(posedge clk) disable iff (!rst_n)
    acc_run |=> busy_o);

  a_r2_load_fourth: assert property (@(posedge clk) disable iff (!rst_n)
    acc_run |-> ##4 (pc_load_o && busy_o));

  a_r3_two_pushes: assert property (@(posedge clk) disable iff (!rst_n)
    acc_run |=> stk_we_o ##1 stk_we_o ##1 !stk_we_o);

  a_r5_gie_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_run || acc_wake) |=> !gie_o);

  a_r6_wake_eighth: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wake |-> ##8 pc_load_o);

  a_r7_return_load: assert property (@(posedge clk) disable iff (!rst_n)
    ret_start |-> ##4 pc_load_o ##1 gie_o);

  a_r7_sp_up_two: assert property (@(posedge clk) disable iff (!rst_n)
    ret_start |-> ##5 (sp_o == $past(sp_o, 5) + SP_W'(2)));

  a_r8_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_done_i && ei_exec_i && !busy_o) |=> !acc_run);

  a_r2_load_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load_o |-> busy_o);
endmodule

bind isr_sequencer isr_seq_checker #(.SP_W(SP_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .insn_done_i (insn_done_i),
  .ei_exec_i   (ei_exec_i),
  .busy_o      (busy_o),
  .pc_load_o   (pc_load_o),
  .gie_o       (gie_o),
  .stk_we_o    (stk_we_o),
  .sp_o        (sp_o),
  .acc_run     (acc_run),
  .acc_wake    (acc_wake),
  .ret_start   (ret_start)
);

// File: tb/sim_isr_sequencer.sv
module sim_isr_sequencer;
  localparam int N = 8;
  localparam int SPW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irq_set = '0;
  logic insn_done = 0, ei = 0, di = 0, reti = 0, sleeping = 0, wake_ready = 0;
  logic [15:0] pc_cur = '0;
  logic [7:0] rdata;
  logic we, pc_load, busy, gie;
  logic [SPW-1:0] addr, sp;
  logic [7:0] wdata;
  logic [15:0] pc_val;
  logic [N-1:0] pend;

  logic [7:0] mem [0:(1<<SPW)-1];
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  always_ff @(posedge clk) if (we) mem[addr] <= wdata;
  assign rdata = mem[addr];

  isr_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .irq_set_i(irq_set), .insn_done_i(insn_done),
    .ei_exec_i(ei), .di_exec_i(di), .reti_exec_i(reti), .sleeping_i(sleeping),
    .wake_ready_i(wake_ready), .pc_cur_i(pc_cur), .stk_rdata_i(rdata),
    .stk_we_o(we), .stk_addr_o(addr), .stk_wdata_o(wdata), .sp_o(sp),
    .pc_load_o(pc_load), .pc_load_val_o(pc_val), .busy_o(busy), .gie_o(gie),
    .irq_pend_o(pend)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int first_set(input logic [N-1:0] m);
    int k = 0;
    while (k < N && !m[k]) k++;
    return k;
  endfunction

  function automatic logic [15:0] exp_vec(input int idx);
    return 16'h0002 + 16'(idx * 2);
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic boundary(input logic e, input logic d, input logic r);
    insn_done = 1; ei = e; di = d; reti = r;
    step();
    insn_done = 0; ei = 0; di = 0; reti = 0;
  endtask

  logic [N-1:0] pm;

  // Entry taken at this boundary; checks every cycle of it.
  task automatic entry(input logic [15:0] pc);
    logic [SPW-1:0] s0 = sp;
    int idx = first_set(pm);
    pc_cur = pc;
    boundary(0, 0, 0);
    chk("R1 busy after accept", busy, 1);
    chk("R5 gie cleared", gie, 0);
    pm[idx] = 1'b0;
    chk("R4 pending after take", pend, pm);
    chk("R3 low byte write", {we, addr, wdata}, {1'b1, s0, pc[7:0]});
    step();
    chk("R3 high byte write", {we, addr, wdata}, {1'b1, s0 - SPW'(1), pc[15:8]});
    step();
    chk("R3 no third write", we, 0);
    chk("R2 no early load", pc_load, 0);
    step();
    chk("R2 vector load", {pc_load, busy, pc_val}, {1'b1, 1'b1, exp_vec(idx)});
    step();
    chk("R2 busy ends", busy, 0);
    chk("R3 sp lowered", sp, s0 - SPW'(2));
  endtask

  task automatic ret(input logic [15:0] pc);
    logic [SPW-1:0] s0 = sp;
    boundary(0, 0, 1);
    chk("R7 busy", busy, 1);
    chk("R7 pop high addr", addr, s0 + SPW'(1));
    step();
    chk("R7 pop low addr", addr, s0 + SPW'(2));
    step();
    step();
    chk("R7 restored load", {pc_load, pc_val}, {1'b1, pc});
    step();
    chk("R7 gie set", {busy, gie}, 2'b01);
    chk("R7 sp raised", sp, s0 + SPW'(2));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] pcs [0:N-1];
    void'($urandom(32'd20240611));
    for (int i = 0; i < (1<<SPW); i++) mem[i] = '0;
    repeat (3) step();
    chk("R11 reset outputs", {busy, gie, we, pc_load, pend}, '0);
    chk("R11 reset sp", sp, 10'h3FF);
    rst_n = 1;
    step();

    // R10: disabled interrupts hold requests pending.
    irq_set = 8'h24; step(); irq_set = '0;
    boundary(0, 0, 0);
    chk("R10 no accept gie off", busy, 0);
    boundary(1, 0, 0);
    boundary(0, 1, 0);  // shadow boundary also disables
    chk("R10 gie cleared", gie, 0);
    repeat (2) boundary(0, 0, 0);
    chk("R10 still pending", {busy, pend}, {1'b0, 8'h24});
    rst_n = 0; step(); rst_n = 1; step();

    // Random rounds: enable, shadow, then drain every pending request.
    for (int it = 0; it < 12; it++) begin
      logic [N-1:0] m = N'($urandom_range(1, (1<<N)-1));
      int depth = 0;
      pm = m;
      irq_set = m; step(); irq_set = '0;
      chk("R4 pending set", pend, pm);
      boundary(0, 0, 0);
      chk("R1 no accept gie off", busy, 0);
      boundary(1, 0, 0);
      chk("R8 gie set", {gie, busy}, 2'b10);
      boundary(0, 0, 0);
      chk("R8 shadow boundary", busy, 0);
      repeat ($urandom_range(0, 4)) begin
        step();
        chk("R1 mid instruction", busy, 0);
      end
      while (pm != 0) begin
        pcs[depth] = 16'($urandom);
        entry(pcs[depth]);
        ret(pcs[depth]);
        depth++;
      end
      boundary(0, 1, 0);
      chk("R10 disable", gie, 0);
    end

    // R6/R9: enable then sleep at the next instruction.
    begin
      logic [SPW-1:0] s0;
      pm = 8'h80;
      irq_set = 8'h80; step(); irq_set = '0;
      boundary(1, 0, 0);
      pc_cur = 16'h1234;
      boundary(0, 0, 0);          // the sleep instruction
      chk("R9 sleep before service", busy, 0);
      sleeping = 1;
      repeat (3) begin
        step();
        chk("R6 wait for ready", busy, 0);
      end
      s0 = sp;
      wake_ready = 1; step(); wake_ready = 0; sleeping = 0;
      chk("R6 busy from wake", {busy, gie}, 2'b10);
      chk("R9 pending cleared", pend, 0);
      repeat (3) begin
        chk("R6 no early write", {we, pc_load}, 0);
        step();
      end
      chk("R6 no early write", {we, pc_load}, 0);
      step();
      chk("R6 low byte", {we, addr, wdata}, {1'b1, s0, 8'h34});
      step();
      chk("R6 high byte", {we, addr, wdata}, {1'b1, s0 - SPW'(1), 8'h12});
      step(); step();
      chk("R6 vector eighth", {pc_load, pc_val}, {1'b1, exp_vec(7)});
      step();
      chk("R6 busy ends", busy, 0);
      ret(16'h1234);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule